// File: doc/BRIEF.md
# Multi-core IPI and Acknowledge Controller

This block is a compact interrupt controller shared by a group of cores. Every core owns two inter-processor interrupt sources and a small set of level-sensitive hardware interrupt lines. The first IPI source, called "self", is raised through the trigger register of the core's own bank. The second, called "other", can be raised by any core, and a single trigger write can raise it on several target cores at once. Each core has one level interrupt output. That output stays high while any of the core's sources is both pending and unmasked.

Each core has its own request port into the controller. A request reaches a bank in one of two ways. It can use a fixed per-core window, or it can use an alias window that always resolves to the bank of the port making the request. Reading the event register of a bank acknowledges an interrupt. The read returns the lowest-ordered source that is pending and unmasked, and it masks that source in the same cycle. Software then clears the pending bit and unmasks the source again.

Top module: `ipi_ack_ctrl`

## Requirements
- R1: Core k's bank sits at byte address 0x5000 + 0x80*k. The window 0x4000 to 0x407F selects the bank of the requesting port. The register offsets are: 0x00 event, 0x08 IPI trigger, 0x0C IPI status, 0x10 IPI mask set (a read returns the IPI mask), 0x14 IPI mask clear, 0x20 hardware mask set (a read returns the hardware mask), 0x24 hardware mask clear, 0x28 hardware raw line level. Read data appears on the port's `rsp_data` lane one clock after the request. Reads of unmapped addresses return 0.
- R2: Writing a word with bit 31 set to a bank's trigger register raises the self IPI of the core that owns that bank, whichever port does the write.
- R3: Writing a word with bit k set (k below 31 and below the core count) to any trigger register raises the other IPI of core k. One write can raise it on several cores.
- R4: In the status and IPI mask registers, the other IPI sits at bit 0 and the self IPI at bit 31. All other bits read 0.
- R5: Writing 1 to a status bit clears that pending IPI. If a trigger and a clear hit the same bit in the same cycle, the bit ends up pending.
- R6: Writing 1s to a mask-set register masks sources, and writing 1s to a mask-clear register unmasks them. If both hit the same bit in one cycle, the bit ends up masked. After reset nothing is pending, the IPI mask reads 0x80000001 and the hardware mask is all ones.
- R7: `irq_out[k]` is high exactly while core k has a pending, unmasked IPI or a high, unmasked hardware line.
- R8: An event read returns the lowest-ordered active source. Hardware lines come first in ascending order, then the other IPI, then the self IPI. The returned word is type<<16 | number. Type 1 is a hardware line, and its number is the line index. Type 2 is an IPI, and its number is 1 for other and 2 for self.
- R9: An event read that returns a source sets that source's mask bit. It does not clear a pending IPI.
- R10: An event read with no active source returns 0 and leaves every mask unchanged.
- R11: When several ports read the same bank's event register in one cycle, only the lowest-numbered port receives the event. The others read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | NUM_CORES*NUM_HW | Hardware lines; core k uses bits [k*NUM_HW +: NUM_HW] |
| req_valid | input | NUM_CORES | Request strobe, one per core port |
| req_write | input | NUM_CORES | 1 = write, 0 = read, per port |
| req_addr | input | NUM_CORES*16 | Byte address, 16 bits per port |
| req_wdata | input | NUM_CORES*32 | Write data, 32 bits per port |
| rsp_data | output | NUM_CORES*32 | Read data, 32 bits per port, one clock after the read |
| irq_out | output | NUM_CORES | Level interrupt, one per core |

## Verification
The per-core ports let two functions hit the same state bit in one cycle. The bench uses this to create three races. In the first, one core triggers another core's other IPI while that core clears the same status bit. The status must then read back as pending. In the second, one port sets a mask bit while a different port clears it, and the mask must read back set. In the third, two ports read the same event register together. Only the lower-numbered port may see the event word, and the acknowledged source must afterwards appear masked with the interrupt output low.

// File: rtl/ipi_ack_pkg.sv
package ipi_ack_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;
    localparam int BANK_ID_W  = 5;
    localparam int BANK_SHIFT = 7;
    localparam int SELF_BIT   = 31;

    localparam logic [ADDR_W-1:0] ALIAS_BASE = 16'h4000;
    localparam logic [ADDR_W-1:0] BANK_BASE  = 16'h5000;

    localparam logic [15:0] KIND_HW   = 16'd1;
    localparam logic [15:0] KIND_IPI  = 16'd2;
    localparam logic [15:0] NUM_OTHER = 16'd1;
    localparam logic [15:0] NUM_SELF  = 16'd2;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_EVENT,
        REG_TRIG,
        REG_STAT,
        REG_IMSET,
        REG_IMCLR,
        REG_HMSET,
        REG_HMCLR,
        REG_HRAW
    } reg_e;

    // One decoded request from one core port.
    typedef struct packed {
        logic                 hit;
        logic                 wr;
        logic [BANK_ID_W-1:0] bank;
        reg_e                 sel;
        logic [DATA_W-1:0]    wdata;
    } acc_t;

    typedef struct packed {
        logic [15:0] kind;
        logic [15:0] num;
    } evt_t;

    // Read-side view of one bank, consumed by the response mux.
    typedef struct packed {
        logic [DATA_W-1:0]    stat;
        logic [DATA_W-1:0]    imask;
        logic [DATA_W-1:0]    hmask;
        logic [DATA_W-1:0]    hraw;
        evt_t                 evt;
        logic                 gnt;
        logic [BANK_ID_W-1:0] gnt_port;
    } view_t;

    function automatic reg_e decode_off(input logic [BANK_SHIFT-1:0] off);
        case (off)
            7'h00:   return REG_EVENT;
            7'h08:   return REG_TRIG;
            7'h0C:   return REG_STAT;
            7'h10:   return REG_IMSET;
            7'h14:   return REG_IMCLR;
            7'h20:   return REG_HMSET;
            7'h24:   return REG_HMCLR;
            7'h28:   return REG_HRAW;
            default: return REG_NONE;
        endcase
    endfunction

    function automatic evt_t make_evt(input logic [15:0] kind, input logic [15:0] num);
        evt_t e;
        e.kind = kind;
        e.num  = num;
        return e;
    endfunction

    // IPI pair placed in a 32-bit word: other at bit 0, self at bit 31.
    function automatic logic [DATA_W-1:0] ipi_word(input logic [1:0] v);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[0]        = v[0];
        w[SELF_BIT] = v[1];
        return w;
    endfunction

endpackage

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
    parameter  int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // R8: the chosen index is requesting and nothing below it is
    always_comb begin
        if (found) begin
            p_pick_lowest_r8: assert (req[idx] && ((req & ((W'(1) << idx) - W'(1))) == '0));
        end
    end

endmodule

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
    import ipi_ack_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int MY_ID     = 0
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output acc_t              acc
);

    localparam logic [31:0] SPAN = 32'(NUM_CORES) << BANK_SHIFT;

    logic [ADDR_W-1:0] rel;
    logic              in_alias;
    logic              in_bank;

    always_comb begin
        rel       = addr - BANK_BASE;
        in_alias  = (addr[ADDR_W-1:BANK_SHIFT] == ALIAS_BASE[ADDR_W-1:BANK_SHIFT]);
        in_bank   = (addr >= BANK_BASE) && (32'(rel) < SPAN);
        acc.hit   = valid && (in_alias || in_bank);
        acc.wr    = write;
        acc.bank  = in_alias ? BANK_ID_W'(MY_ID) : rel[BANK_SHIFT +: BANK_ID_W];
        acc.sel   = decode_off(addr[BANK_SHIFT-1:0]);
        acc.wdata = wdata;
    end

endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
    import ipi_ack_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int NUM_HW    = 4,
    parameter int MY_ID     = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc [NUM_CORES],
    input  logic [NUM_HW-1:0] hw_lvl,
    output view_t             view,
    output logic              irq
);

    localparam int SRC_W     = NUM_HW + 2;
    localparam int SRC_IW    = $clog2(SRC_W);
    localparam int PORT_IW   = $clog2(NUM_CORES);
    localparam int OTHER_IDX = NUM_HW;

    logic [1:0]        pend_q, imask_q;
    logic [NUM_HW-1:0] hmask_q;

    logic [1:0]           raise, clr, imset, imclr;
    logic [NUM_HW-1:0]    hmset, hmclr;
    logic [NUM_CORES-1:0] own, rd_req;

    logic               rd_gnt;
    logic [PORT_IW-1:0] rd_port;
    logic [SRC_W-1:0]   active, all_mask, ack_vec;
    logic               src_found;
    logic [SRC_IW-1:0]  src_idx;
    evt_t               evt;

    // Gather the effect of every port on this bank
    always_comb begin
        raise  = '0;
        clr    = '0;
        imset  = '0;
        imclr  = '0;
        hmset  = '0;
        hmclr  = '0;
        own    = '0;
        rd_req = '0;
        for (int p = 0; p < NUM_CORES; p++) begin
            own[p] = acc[p].hit && (acc[p].bank == BANK_ID_W'(MY_ID));
            if (acc[p].hit && acc[p].wr && acc[p].sel == REG_TRIG)
                raise[0] = raise[0] | acc[p].wdata[MY_ID];
            if (own[p] && acc[p].wr) begin
                case (acc[p].sel)
                    REG_TRIG:  raise[1] = raise[1] | acc[p].wdata[SELF_BIT];
                    REG_STAT:  clr   = clr   | {acc[p].wdata[SELF_BIT], acc[p].wdata[0]};
                    REG_IMSET: imset = imset | {acc[p].wdata[SELF_BIT], acc[p].wdata[0]};
                    REG_IMCLR: imclr = imclr | {acc[p].wdata[SELF_BIT], acc[p].wdata[0]};
                    REG_HMSET: hmset = hmset | acc[p].wdata[NUM_HW-1:0];
                    REG_HMCLR: hmclr = hmclr | acc[p].wdata[NUM_HW-1:0];
                    default:   ;
                endcase
            end
            rd_req[p] = own[p] && !acc[p].wr && (acc[p].sel == REG_EVENT);
        end
    end

    ipi_lowest_pick #(.W(NUM_CORES)) u_port_pick (
        .req   (rd_req),
        .found (rd_gnt),
        .idx   (rd_port)
    );

    assign active   = {pend_q & ~imask_q, hw_lvl & ~hmask_q};
    assign all_mask = {imask_q, hmask_q};

    ipi_lowest_pick #(.W(SRC_W)) u_src_pick (
        .req   (active),
        .found (src_found),
        .idx   (src_idx)
    );

    always_comb begin
        if (!src_found)
            evt = '0;
        else if (32'(src_idx) < NUM_HW)
            evt = make_evt(KIND_HW, 16'(src_idx));
        else if (32'(src_idx) == OTHER_IDX)
            evt = make_evt(KIND_IPI, NUM_OTHER);
        else
            evt = make_evt(KIND_IPI, NUM_SELF);
        ack_vec = (rd_gnt && src_found) ? (SRC_W'(1) << src_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            imask_q <= '1;
            hmask_q <= '1;
        end else begin
            pend_q  <= (pend_q & ~clr) | raise;
            imask_q <= (imask_q & ~imclr) | imset | ack_vec[SRC_W-1 -: 2];
            hmask_q <= (hmask_q & ~hmclr) | hmset | ack_vec[NUM_HW-1:0];
        end
    end

    always_comb begin
        view.stat     = ipi_word(pend_q);
        view.imask    = ipi_word(imask_q);
        view.hmask    = DATA_W'(hmask_q);
        view.hraw     = DATA_W'(hw_lvl);
        view.evt      = evt;
        view.gnt      = rd_gnt;
        view.gnt_port = BANK_ID_W'(rd_port);
    end

    assign irq = |active;

    // R5: a raise meeting a clear on the other IPI leaves it pending
    p_trig_beats_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (raise[0] && clr[0]) |=> pend_q[0]);

    // R5: a clear of the self IPI without a raise empties it
    p_stat_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr[1] && !raise[1]) |=> !pend_q[1]);

    // R6: mask set beats mask clear on the same bit
    p_mask_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (imset[0] && imclr[0]) |=> imask_q[0]);

    // R9: the acknowledged source is masked on the next cycle
    p_ack_masks_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_gnt && src_found) |=> all_mask[$past(src_idx)]);

    // R10: an empty event read with no mask writes changes no mask
    p_idle_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_gnt && !src_found && imset == '0 && imclr == '0 && hmset == '0 && hmclr == '0)
        |=> $stable(all_mask));

endmodule

// File: rtl/ipi_ack_ctrl.sv
module ipi_ack_ctrl
    import ipi_ack_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int NUM_HW    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CORES*NUM_HW-1:0]   hw_irq,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [NUM_CORES-1:0]          req_write,
    input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
    input  logic [NUM_CORES*DATA_W-1:0]   req_wdata,
    output logic [NUM_CORES*DATA_W-1:0]   rsp_data,
    output logic [NUM_CORES-1:0]          irq_out
);

    acc_t              acc  [NUM_CORES];
    view_t             view [NUM_CORES];
    view_t             pv   [NUM_CORES];
    logic [DATA_W-1:0] rd_d [NUM_CORES];
    logic [DATA_W-1:0] rd_q [NUM_CORES];

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
        ipi_port_decode #(.NUM_CORES(NUM_CORES), .MY_ID(p)) u_dec (
            .valid (req_valid[p]),
            .write (req_write[p]),
            .addr  (req_addr[p*ADDR_W +: ADDR_W]),
            .wdata (req_wdata[p*DATA_W +: DATA_W]),
            .acc   (acc[p])
        );
        assign rsp_data[p*DATA_W +: DATA_W] = rd_q[p];
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        ipi_core_bank #(.NUM_CORES(NUM_CORES), .NUM_HW(NUM_HW), .MY_ID(c)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .acc    (acc),
            .hw_lvl (hw_irq[c*NUM_HW +: NUM_HW]),
            .view   (view[c]),
            .irq    (irq_out[c])
        );
    end

    // Read response mux: pick the addressed bank, then the register
    always_comb begin
        for (int p = 0; p < NUM_CORES; p++) begin
            pv[p]   = '0;
            rd_d[p] = '0;
            for (int c = 0; c < NUM_CORES; c++) begin
                if (acc[p].bank == BANK_ID_W'(c))
                    pv[p] = view[c];
            end
            if (acc[p].hit && !acc[p].wr) begin
                case (acc[p].sel)
                    REG_EVENT: begin
                        if (pv[p].gnt && pv[p].gnt_port == BANK_ID_W'(p))
                            rd_d[p] = pv[p].evt;
                    end
                    REG_STAT:             rd_d[p] = pv[p].stat;
                    REG_IMSET, REG_IMCLR: rd_d[p] = pv[p].imask;
                    REG_HMSET, REG_HMCLR: rd_d[p] = pv[p].hmask;
                    REG_HRAW:             rd_d[p] = pv[p].hraw;
                    default:              rd_d[p] = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_CORES; p++) begin
            if (rst) rd_q[p] <= '0;
            else     rd_q[p] <= rd_d[p];
        end
    end

endmodule

// File: tb/ipi_ack_ctrl_test.sv
module ipi_ack_ctrl_test;

    localparam int N = 8;
    localparam int H = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic [N*H-1:0] hw_irq;
    logic [N-1:0]   req_valid, req_write;
    logic [N*16-1:0] req_addr;
    logic [N*32-1:0] req_wdata;
    logic [N*32-1:0] rsp_data;
    logic [N-1:0]   irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ipi_ack_ctrl #(.NUM_CORES(N), .NUM_HW(H)) uut (
        .clk(clk), .rst(rst), .hw_irq(hw_irq),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_data(rsp_data), .irq_out(irq_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] bk(int c, logic [15:0] off);
        return 16'h5000 + 16'(c * 128) + off;
    endfunction

    task automatic idle();
        req_valid = '0;
        req_write = '0;
    endtask

    task automatic put(int p, bit w, logic [15:0] a, logic [31:0] d);
        req_valid[p]          = 1'b1;
        req_write[p]          = w;
        req_addr[p*16 +: 16]  = a;
        req_wdata[p*32 +: 32] = d;
    endtask

    task automatic wr(int p, logic [15:0] a, logic [31:0] d);
        @(negedge clk); put(p, 1'b1, a, d);
        @(negedge clk); idle();
    endtask

    task automatic rd(int p, logic [15:0] a, output logic [31:0] d);
        @(negedge clk); put(p, 1'b0, a, 32'h0);
        @(negedge clk); idle();
        d = rsp_data[p*32 +: 32];
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R7 reset irq_out", 32'(irq_out), 32'h0);
        rd(0, bk(0, 16'h0C), d); chk("R4 reset status", d, 32'h0);
        rd(0, bk(0, 16'h10), d); chk("R6 reset ipi mask", d, 32'h8000_0001);
        rd(0, bk(0, 16'h20), d); chk("R6 reset hw mask", d, 32'h0000_000F);
        rd(0, 16'h0100, d);      chk("R1 unmapped read", d, 32'h0);
    endtask

    task automatic t_self();
        logic [31:0] d;
        wr(3, 16'h4008, 32'h8000_0000);
        rd(0, bk(3, 16'h0C), d); chk("R2 self via alias", d, 32'h8000_0000);
        wr(0, bk(5, 16'h08), 32'h8000_0000);
        rd(5, 16'h400C, d);      chk("R2 self into other bank", d, 32'h8000_0000);
        rd(0, 16'h400C, d);      chk("R1 writer bank untouched", d, 32'h0);
    endtask

    task automatic t_other();
        logic [31:0] d;
        wr(2, 16'h4008, 32'h0000_0012);
        rd(0, bk(1, 16'h0C), d); chk("R3 other core1", d, 32'h1);
        rd(0, bk(4, 16'h0C), d); chk("R3 other core4", d, 32'h1);
        rd(0, bk(2, 16'h0C), d); chk("R3 writer not raised", d, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(1, 16'h400C, 32'h1);
        rd(1, 16'h400C, d); chk("R5 clear other", d, 32'h0);
        wr(3, 16'h400C, 32'h8000_0000);
        rd(3, 16'h400C, d); chk("R5 clear self", d, 32'h0);
        // trigger and clear on the same bit in one cycle
        @(negedge clk);
        put(0, 1'b1, 16'h4008, 32'h0000_0002);
        put(1, 1'b1, 16'h400C, 32'h0000_0001);
        @(negedge clk); idle();
        rd(1, 16'h400C, d); chk("R5 trigger beats clear", d, 32'h1);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(4, 16'h4014, 32'h8000_0001);
        rd(4, 16'h4010, d); chk("R6 mask clear", d, 32'h0);
        @(negedge clk);
        put(4, 1'b1, 16'h4010, 32'h1);
        put(2, 1'b1, bk(4, 16'h14), 32'h1);
        @(negedge clk); idle();
        rd(4, 16'h4010, d); chk("R6 set beats clear", d, 32'h1);
    endtask

    task automatic t_irq();
        chk("R7 masked pending no irq", 32'(irq_out[4]), 32'h0);
        wr(4, 16'h4014, 32'h1);
        chk("R7 unmasked pending irq", 32'(irq_out[4]), 32'h1);
        wr(4, 16'h400C, 32'h1);
        chk("R7 cleared no irq", 32'(irq_out[4]), 32'h0);
    endtask

    task automatic t_event();
        logic [31:0] d;
        @(negedge clk);
        hw_irq[6*H + 2] = 1'b1;
        hw_irq[6*H + 3] = 1'b1;
        @(negedge clk);
        chk("R7 hw masked no irq", 32'(irq_out[6]), 32'h0);
        wr(6, 16'h4024, 32'h0000_000C);
        chk("R7 hw unmasked irq", 32'(irq_out[6]), 32'h1);
        wr(0, 16'h4008, 32'h0000_0040);
        wr(6, bk(6, 16'h14), 32'h1);
        rd(6, 16'h4000, d); chk("R8 first event hw2", d, 32'h0001_0002);
        rd(6, 16'h4000, d); chk("R8 second event hw3", d, 32'h0001_0003);
        rd(6, 16'h4000, d); chk("R8 third event other", d, 32'h0002_0001);
        chk("R9 irq low after acks", 32'(irq_out[6]), 32'h0);
        rd(6, 16'h4020, d); chk("R9 hw mask set by ack", d, 32'h0000_000F);
        rd(6, 16'h4010, d); chk("R9 ipi mask set by ack", d, 32'h8000_0001);
        rd(6, 16'h400C, d); chk("R9 ack keeps pending", d, 32'h1);
        rd(6, 16'h4000, d); chk("R10 empty event", d, 32'h0);
        rd(6, 16'h4010, d); chk("R10 ipi mask unchanged", d, 32'h8000_0001);
        rd(6, 16'h4020, d); chk("R10 hw mask unchanged", d, 32'h0000_000F);
        rd(6, 16'h4028, d); chk("R1 hw raw level", d, 32'h0000_000C);
    endtask

    task automatic t_dual();
        logic [31:0] d1, d5;
        wr(7, 16'h4008, 32'h8000_0000);
        wr(7, 16'h4014, 32'h8000_0000);
        chk("R7 self irq", 32'(irq_out[7]), 32'h1);
        @(negedge clk);
        put(1, 1'b0, bk(7, 16'h00), 32'h0);
        put(5, 1'b0, bk(7, 16'h00), 32'h0);
        @(negedge clk); idle();
        d1 = rsp_data[1*32 +: 32];
        d5 = rsp_data[5*32 +: 32];
        chk("R11 low port gets event", d1, 32'h0002_0002);
        chk("R11 high port reads zero", d5, 32'h0);
        chk("R11 single ack masks", 32'(irq_out[7]), 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        hw_irq    = '0;
        req_valid = '0;
        req_write = '0;
        req_addr  = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_self();
        t_other();
        t_clear();
        t_mask();
        t_irq();
        t_event();
        t_dual();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule